// File: doc/BRIEF.md
# Preloaded Cascaded Frequency Divider

This block divides its clock by a programmable modulus. The count register is made of equal-width stages on a single clock. A stage advances only when every stage below it is at its terminal value, so the whole chain behaves as one wide counter.

The modulus is not compared against the count. Each stage is instead loaded with a start value chosen so that the chain reaches its terminal state after exactly `modulus` enabled cycles. In up mode the start value is the full-scale count minus the modulus, plus one. In down mode the start value is the modulus minus one, and the count runs down to zero.

When the chain is at its terminal state, a one-cycle carry pulse is produced. The same pulse reloads every stage with the start value. A toggle register driven by the carry turns the narrow pulse into a square wave of twice the modulus period with equal high and low times. A preset strobe loads the start value at any time, and an enable freezes the count and the square wave.

Top module: `preload_divider`

## Requirements
- R1: While `rst` is high, each clock edge loads the count with the start value for the current `modulus` and `dn_up`, and sets `sq_out` to 0.
- R2: When `dn_up` is 0, the start value is 256 − `modulus`, taken modulo 256. The count then rises by one on each enabled edge, and `carry_out` is high while the count equals 255 and `en` is high.
- R3: When `dn_up` is 1, the start value is `modulus` − 1, taken modulo 256. The count then falls by one on each enabled edge, and `carry_out` is high while the count equals 0 and `en` is high.
- R4: An edge on which `carry_out` is high reloads the start value. With `en` held high, `carry_out` therefore rises once every `modulus` cycles, and a `modulus` of 0 gives a period of 256.
- R5: An edge on which `preset` is high loads the start value. This takes priority over counting and also works while `en` is low.
- R6: While `en` is low and `preset` is low, the count and `sq_out` hold their values, and `carry_out` is low.
- R7: `sq_out` inverts on every edge on which `carry_out` is high, and at no other edge.
- R8: A change of `modulus` during counting takes effect at the next load, which is either a reload or a preset.
- R9: With `modulus` = 103 in up mode (start value 153), `carry_out` pulses are exactly 103 cycles apart. `sq_out` then stays high for 103 cycles and low for 103 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| preset | input | 1 | Synchronous load of the start value |
| en | input | 1 | Count enable |
| dn_up | input | 1 | 0 counts up, 1 counts down |
| modulus | input | 8 | Division ratio; 0 means 256 |
| carry_out | output | 1 | One-cycle pulse at the terminal count |
| sq_out | output | 1 | Square wave at half the carry rate |

## Verification
A wrong start value or a stage that advances at the wrong time does not show up immediately. It first appears as a carry pulse that arrives early or late, which can take up to a full modulus period of 256 cycles. The bench therefore compares `carry_out` and `sq_out` against a behavioural count model on every cycle, so the first misplaced pulse is reported in the cycle it occurs. A toggle error appears at `sq_out` on the edge right after the carry pulse.

// File: rtl/preload_divider.sv
module preload_divider #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2,
  localparam int CW = STAGE_W * STAGES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          preset,
  input  logic          en,
  input  logic          dn_up,
  input  logic [CW-1:0] modulus,
  output logic          carry_out,
  output logic          sq_out
);

  logic [CW-1:0]   start_val;
  logic [CW-1:0]   cnt;
  logic [STAGES:0] chain_en;
  logic [STAGES-1:0] at_end;
  logic            load;

  assign start_val   = dn_up ? (modulus - CW'(1)) : (~modulus + CW'(1));
  assign chain_en[0] = en;
  assign carry_out   = chain_en[STAGES];
  assign load        = rst | preset | carry_out;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [STAGE_W-1:0] q;
    assign at_end[s]     = dn_up ? (q == '0) : (&q);
    assign chain_en[s+1] = chain_en[s] & at_end[s];
    assign cnt[s*STAGE_W +: STAGE_W] = q;

    always_ff @(posedge clk) begin
      if (load)
        q <= start_val[s*STAGE_W +: STAGE_W];
      else if (chain_en[s])
        q <= dn_up ? q - STAGE_W'(1) : q + STAGE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            sq_out <= 1'b0;
    else if (carry_out) sq_out <= ~sq_out;
  end

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    carry_out |=> cnt == $past(start_val));
  assert_preset_R5: assert property (@(posedge clk) disable iff (rst)
    preset |=> cnt == $past(start_val));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && !preset) |=> $stable(cnt) && $stable(sq_out));
  assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    carry_out |=> sq_out != $past(sq_out));
  assert_steady_R7: assert property (@(posedge clk) disable iff (rst)
    !carry_out |=> $stable(sq_out));
  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !en |-> !carry_out);

endmodule

// File: tb/test_preload_divider.sv
module test_preload_divider;
  logic clk = 1'b0;
  logic rst = 1'b1, preset = 1'b0, en = 1'b0, dn_up = 1'b0;
  logic [7:0] modulus = 8'd103;
  logic carry_out, sq_out;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";
  int ref_cnt = 0;
  bit ref_sq = 0;
  int cyc = 0, last_carry = -1, last_sq_edge = -1;
  bit meas = 0;

  preload_divider i_preload_divider (.clk(clk), .rst(rst), .preset(preset), .en(en),
    .dn_up(dn_up), .modulus(modulus), .carry_out(carry_out), .sq_out(sq_out));

  always #4 clk = ~clk;

  function automatic int start_of(int m, bit dn);
    if (m == 0) return dn ? 255 : 0;
    return dn ? m - 1 : 256 - m;
  endfunction

  function automatic bit ref_carry();
    return en && (dn_up ? (ref_cnt == 0) : (ref_cnt == 255));
  endfunction

  always @(posedge clk) begin
    bit c;
    c = ref_carry();
    if (rst) begin
      ref_cnt = start_of(modulus, dn_up);
      ref_sq = 0;
    end else begin
      if (c) ref_sq = ~ref_sq;
      if (preset || c) ref_cnt = start_of(modulus, dn_up);
      else if (en) ref_cnt = dn_up ? (ref_cnt + 255) % 256 : (ref_cnt + 1) % 256;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      check({tag, " carry_out"}, carry_out, ref_carry());
      check({tag, " sq_out"}, sq_out, ref_sq);
      if (meas) begin
        if (carry_out) begin
          if (last_carry >= 0) check("R9 carry spacing", cyc - last_carry, 103);
          last_carry = cyc;
        end
        if (sq_out != ref_sq) ;
      end
    end
  endtask

  task automatic measure_sq();
    int t0, t1, t2;
    @(negedge clk); while (sq_out) @(negedge clk);
    while (!sq_out) @(negedge clk);
    t0 = cyc;
    while (sq_out) begin @(negedge clk); cyc++; end
    t1 = cyc;
    while (!sq_out) begin @(negedge clk); cyc++; end
    t2 = cyc;
    check("R9 sq high time", t1 - t0, 103);
    check("R9 sq low time", t2 - t1, 103);
  endtask

  initial begin
    tag = "R1";
    step(3);
    check("R1 sq after reset", sq_out, 0);
    check("R1 carry after reset", carry_out, 0);
    rst = 0; en = 1; tag = "R2";
    meas = 1;
    step(500);
    meas = 0;
    tag = "R9";
    measure_sq();
    tag = "R7";
    step(50);
    tag = "R3";
    dn_up = 1; modulus = 8'd10; preset = 1;
    step(1);
    preset = 0;
    step(60);
    tag = "R6";
    for (int i = 0; i < 200; i++) begin
      en = $urandom_range(0, 1);
      step(1);
    end
    en = 0; tag = "R5";
    modulus = 8'd7; preset = 1;
    step(1);
    preset = 0;
    step(5);
    en = 1;
    step(40);
    tag = "R8";
    modulus = 8'd20;
    step(60);
    dn_up = 0; modulus = 8'd5;
    step(40);
    tag = "R4";
    modulus = 8'd1; preset = 1;
    step(1);
    preset = 0;
    step(10);
    modulus = 8'd0; preset = 1;
    step(1);
    preset = 0;
    step(600);
    dn_up = 1; preset = 1;
    step(1);
    preset = 0;
    step(600);
    tag = "R1";
    rst = 1;
    step(2);
    rst = 0;
    step(20);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule